// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a processor's peripheral bus. Software reaches four registers through a small select/write/address bus. These are a data port, a rate divisor, a character format word and a status word. The transmit and receive paths each put a one-character holding register in front of the shift register. This lets the processor or an external DMA engine prepare the next character while the current one is still on the line.

The character format is set at run time: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. A full frame is therefore 7 to 12 bit times long. The bit time is 16 oversample ticks. Each tick lasts D peripheral clocks, where D is taken from the divisor register. The receiver samples in the middle of each bit and rejects start pulses that are too short. It reports parity, framing and overrun errors together with the character. A transmit interrupt and a receive interrupt are enabled separately. A request/acknowledge pair per direction lets a DMA engine move characters without software.

Top module: `uart_port`

## Requirements
- R1: Register addresses are 0 data, 1 divisor, 2 format, 3 status. After reset: status reads 0x0003, txd is high, both interrupts are low, divisor reads 1, and format reads 0x0003 (8 data bits, 1 stop, no parity, both interrupts masked).
- R2: A transmitted frame has these parts, in order: a low start bit; then format[1:0]+5 data bits, LSB first; then a parity bit if format[3] is set; then one stop bit, or two if format[2] is set, both high. With format[4]=0 (even) the parity bit makes the count of ones in data plus parity even. With format[4]=1 (odd) it makes that count odd.
- R3: Every bit lasts 16×D peripheral clocks. D is the divisor register value, and a value of 0 means D=65536.
- R4: A write to address 0 fills the empty transmit holding register. The holding register moves into the shifter as soon as the shifter is idle. A write while the holding register is full is ignored. Status bit 0 shows holding-empty. Status bit 1 shows that the transmitter is fully idle, and txd is high whenever that bit is set.
- R5: The receiver samples each bit at the middle of its 16 ticks. A finished character appears right-aligned on reads of address 0 and sets status bit 2 (ready). Reading address 0 clears ready.
- R6: After a falling edge the start bit is checked at mid-bit. If the line is high again at that point, the receiver returns to idle and delivers nothing.
- R7: A parity mismatch sets status bit 4. A low first stop bit sets status bit 5. Both belong to the delivered character and clear when address 0 is read.
- R8: If a character completes while ready is set, the stored character is kept and status bit 3 (overrun) is set. Overrun clears when address 0 is read.
- R9: irq_tx equals format[5] AND holding-empty. irq_rx equals format[6] AND (ready OR overrun).
- R10: dma_tx_req is high while the transmit holding register is empty. dma_tx_ack loads wdata[7:0] into it. dma_rx_req is high while ready is set. dma_rx_ack shows the received character on rdata and consumes it, like a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data (also DMA transmit data) |
| rdata | output | 16 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_tx_ack | input | 1 | Transmit DMA acknowledge, writes wdata[7:0] |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_rx_ack | input | 1 | Receive DMA acknowledge, consumes character |

## Verification
The bench builds the block with its default 16-bit divisor. It then programs the divisor at run time to 1, 2 and 3, so that every character length, parity mode and stop-bit count fits in a frame of a few hundred clocks. One directed run writes a divisor of 0 and confirms that the start bit still lasts after 20000 clocks. This shows the wrap to 65536 without simulating a full frame. The short divisors keep false-start pulses, back-to-back overruns and injected parity and stop-bit errors cheap enough to mix with random traffic.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int CHAR_W = 8;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_FMT  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
    } phase_e;

    typedef struct packed {
        logic       odd;
        logic       par_en;
        logic       stop2;
        logic [1:0] len;
    } frame_cfg_t;

    typedef struct packed {
        logic              fe;
        logic              pe;
        logic [CHAR_W-1:0] data;
    } rx_word_t;

    // index of the last data bit for a length code
    function automatic logic [2:0] last_bit(input logic [1:0] len);
        return 3'(len) + 3'd4;
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [1:0] len, input logic odd);
        return (^(d & len_mask(len))) ^ odd;
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb
        last = (divisor == '0) ? {1'b0, {DIV_W{1'b1}}} : CW'(divisor) - CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              thr_empty,
    output logic              idle,
    output logic              txd
);
    localparam int CW = $clog2(OVS);

    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic [2:0]        bitn;
    logic [CHAR_W-1:0] hold, shreg;
    logic              hold_full, par;

    assign thr_empty = !hold_full;
    assign idle      = (phase == PH_IDLE) && !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            hold      <= '0;
            shreg     <= '0;
            hold_full <= 1'b0;
            par       <= 1'b0;
            txd       <= 1'b1;
        end else begin
            if (wr_en && !hold_full) begin
                hold      <= wr_data;
                hold_full <= 1'b1;
            end
            if (phase == PH_IDLE) begin
                if (hold_full) begin
                    shreg     <= hold;
                    par       <= parity_of(hold, cfg.len, cfg.odd);
                    hold_full <= 1'b0;
                    phase     <= PH_START;
                    cnt       <= '0;
                    txd       <= 1'b0;
                end
            end else if (tick) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt <= '0;
                    unique case (phase)
                        PH_START: begin
                            phase <= PH_DATA;
                            bitn  <= '0;
                            txd   <= shreg[0];
                        end
                        PH_DATA: begin
                            if (bitn == last_bit(cfg.len)) begin
                                bitn  <= '0;
                                phase <= cfg.par_en ? PH_PAR : PH_STOP;
                                txd   <= cfg.par_en ? par : 1'b1;
                            end else begin
                                bitn  <= bitn + 3'd1;
                                shreg <= shreg >> 1;
                                txd   <= shreg[1];
                            end
                        end
                        PH_PAR: begin
                            phase <= PH_STOP;
                            txd   <= 1'b1;
                        end
                        PH_STOP: begin
                            if (cfg.stop2 && bitn == 3'd0) bitn <= 3'd1;
                            else phase <= PH_IDLE;
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    input  logic       pop,
    output rx_word_t   word,
    output logic       ready,
    output logic       ovr
);
    localparam int CW = $clog2(OVS);

    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic [2:0]        bitn;
    logic [CHAR_W-1:0] shreg;
    logic              s1, s2, s3, acc, perr;

    always_ff @(posedge clk) begin
        if (rst) begin
            {s1, s2, s3} <= 3'b111;
            phase <= PH_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            acc   <= 1'b0;
            perr  <= 1'b0;
            word  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
            if (pop) begin
                ready   <= 1'b0;
                ovr     <= 1'b0;
                word.pe <= 1'b0;
                word.fe <= 1'b0;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (s3 && !s2) begin
                        phase <= PH_START;
                        cnt   <= '0;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (cnt == CW'(OVS / 2 - 1)) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            shreg <= '0;
                            acc   <= 1'b0;
                            perr  <= 1'b0;
                            phase <= s2 ? PH_IDLE : PH_DATA;
                        end else cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    if (tick) begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            if (phase == PH_DATA) begin
                                shreg[bitn] <= s2;
                                acc         <= acc ^ s2;
                                bitn        <= bitn + 3'd1;
                                if (bitn == last_bit(cfg.len))
                                    phase <= cfg.par_en ? PH_PAR : PH_STOP;
                            end else if (phase == PH_PAR) begin
                                perr  <= acc ^ s2 ^ cfg.odd;
                                phase <= PH_STOP;
                            end else begin
                                phase <= PH_IDLE;
                                if (ready && !pop) begin
                                    ovr <= 1'b1;
                                end else begin
                                    word  <= '{fe: !s2, pe: perr, data: shreg};
                                    ready <= 1'b1;
                                end
                            end
                        end else cnt <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_port.sv
module uart_port
    import uart_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        dma_tx_req,
    input  logic        dma_tx_ack,
    output logic        dma_rx_req,
    input  logic        dma_rx_ack
);
    logic [DIV_W-1:0] div_q;
    frame_cfg_t       cfg;
    logic             txie, rxie, tick;
    logic             tx_wr, thr_empty, tx_idle;
    logic             rx_pop, rx_ready, rx_ovr;
    rx_word_t         rx_word;

    assign tx_wr  = (sel && wr && addr == A_DATA) || dma_tx_ack;
    assign rx_pop = (sel && !wr && addr == A_DATA) || dma_rx_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_W'(1);
            cfg   <= '{odd: 1'b0, par_en: 1'b0, stop2: 1'b0, len: 2'd3};
            txie  <= 1'b0;
            rxie  <= 1'b0;
        end else if (sel && wr) begin
            if (addr == A_DIV) div_q <= wdata[DIV_W-1:0];
            if (addr == A_FMT) begin
                cfg  <= frame_cfg_t'(wdata[4:0]);
                txie <= wdata[5];
                rxie <= wdata[6];
            end
        end
    end

    uart_baud #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst(rst), .divisor(div_q), .tick(tick)
    );

    uart_tx #(.OVS(OVS)) i_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .wr_en(tx_wr),
        .wr_data(wdata[CHAR_W-1:0]), .thr_empty(thr_empty), .idle(tx_idle),
        .txd(txd)
    );

    uart_rx #(.OVS(OVS)) i_rx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .rxd(rxd),
        .pop(rx_pop), .word(rx_word), .ready(rx_ready), .ovr(rx_ovr)
    );

    always_comb begin
        if (dma_rx_ack) rdata = 16'(rx_word.data);
        else begin
            unique case (addr)
                A_DATA:  rdata = 16'(rx_word.data);
                A_DIV:   rdata = 16'(div_q);
                A_FMT:   rdata = {9'd0, rxie, txie, cfg};
                default: rdata = {10'd0, rx_word.fe, rx_word.pe, rx_ovr,
                                  rx_ready, tx_idle, thr_empty};
            endcase
        end
    end

    assign irq_tx     = txie && thr_empty;
    assign irq_rx     = rxie && (rx_ready || rx_ovr);
    assign dma_tx_req = thr_empty;
    assign dma_rx_req = rx_ready;
endmodule

// File: rtl/uart_port_chk.sv
module uart_port_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic tx_wr,
    input logic thr_empty,
    input logic tx_idle,
    input logic rx_ready,
    input logic rx_pop,
    input logic rx_ovr
);
    // R4
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && thr_empty) |=> !thr_empty);

    // R4
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rx_pop) |=> rx_ready);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr && !rx_pop) |=> rx_ovr);

    // R8
    ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> rx_ready);
endmodule

bind uart_port uart_port_chk i_chk (
    .clk(clk), .rst(rst), .txd(txd), .tx_wr(tx_wr), .thr_empty(thr_empty),
    .tx_idle(tx_idle), .rx_ready(rx_ready), .rx_pop(rx_pop), .rx_ovr(rx_ovr)
);

// File: tb/test_uart_port.sv
module test_uart_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        rxd = 1'b1;
    logic        txd, irq_tx, irq_rx, dma_tx_req, dma_rx_req;
    logic        dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_port i_uart_port (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .dma_tx_req(dma_tx_req), .dma_tx_ack(dma_tx_ack),
        .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] len, input logic odd);
        return (^(d & mask_of(len))) ^ odd;
    endfunction

    function automatic logic [15:0] fmt_word(input logic [1:0] len, input logic st2,
                                             input logic pen, input logic odd);
        return {11'd0, odd, pen, st2, len};
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    // waits for a frame on txd and compares every bit mid-bit
    task automatic tx_expect(input logic [7:0] d, input logic [1:0] len, input logic st2,
                             input logic pen, input logic odd, input int dv, input string req);
        logic [11:0] exp_bits, got;
        int n;
        exp_bits = '0; got = '0; n = 0;
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < len + 5; i++) exp_bits[n++] = d[i];
        if (pen) exp_bits[n++] = par_of(d, len, odd);
        exp_bits[n++] = 1'b1;
        if (st2) exp_bits[n++] = 1'b1;
        while (txd) @(negedge clk);
        repeat (8 * dv) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i != n - 1) repeat (16 * dv) @(negedge clk);
        end
        check(got == exp_bits, req, int'(got), int'(exp_bits));
    endtask

    task automatic rx_send(input logic [7:0] d, input logic [1:0] len, input logic st2,
                           input logic pen, input logic odd, input logic flip,
                           input logic bad_stop, input int dv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (16 * dv) @(negedge clk);
        for (int i = 0; i < len + 5; i++) begin
            rxd = d[i];
            repeat (16 * dv) @(negedge clk);
        end
        if (pen) begin
            rxd = par_of(d, len, odd) ^ flip;
            repeat (16 * dv) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (16 * dv) @(negedge clk);
        rxd = 1'b1;
        if (st2) repeat (16 * dv) @(negedge clk);
        repeat (32 * dv) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  d, a, b;
        logic [1:0]  len;
        logic        st2, pen, odd, flip, bst;
        int          dv;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1 && irq_tx == 1'b0 && irq_rx == 1'b0, "R1 lines", {txd, irq_tx, irq_rx}, 3'b100);
        bus_rd(2'd3, r); check(r == 16'h0003, "R1 status", r, 16'h0003);
        bus_rd(2'd1, r); check(r == 16'h0001, "R1 divisor", r, 16'h0001);
        bus_rd(2'd2, r); check(r == 16'h0003, "R1 format", r, 16'h0003);

        // R2 R3 random transmit formats and divisors
        for (int k = 0; k < 12; k++) begin
            d = 8'($urandom); len = 2'($urandom); st2 = 1'($urandom);
            pen = 1'($urandom); odd = 1'($urandom); dv = 1 + int'($urandom % 3);
            if (k < 4) begin len = 2'(k); pen = 1'b1; odd = k[0]; st2 = k[1]; end
            bus_wr(2'd1, 16'(dv));
            bus_wr(2'd2, fmt_word(len, st2, pen, odd));
            bus_wr(2'd0, {8'd0, d});
            tx_expect(d, len, st2, pen, odd, dv, "R2 R3 tx frame");
            repeat (40 * dv) @(negedge clk);
        end

        // R4 double buffer: A shifts, B held, C ignored
        bus_wr(2'd1, 16'd1);
        bus_wr(2'd2, fmt_word(2'd3, 1'b0, 1'b0, 1'b0));
        bus_wr(2'd0, 16'h00A5);
        bus_wr(2'd0, 16'h003C);
        bus_wr(2'd0, 16'h00FF);
        bus_rd(2'd3, r); check(r[1:0] == 2'b00, "R4 holding full", r[1:0], 0);
        tx_expect(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1, "R4 first char");
        tx_expect(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1, "R4 second char");
        begin
            bit fell = 1'b0;
            repeat (400) begin @(negedge clk); if (!txd) fell = 1'b1; end
            check(!fell, "R4 third write ignored", fell, 0);
        end
        bus_rd(2'd3, r); check(r[1:0] == 2'b11, "R4 idle again", r[1:0], 3);

        // R5 R7 random receive traffic with injected errors
        for (int k = 0; k < 12; k++) begin
            d = 8'($urandom); len = 2'($urandom); st2 = 1'($urandom);
            pen = 1'($urandom); odd = 1'($urandom); dv = 1 + int'($urandom % 3);
            flip = pen && ($urandom % 3 == 0);
            bst = (k % 4 == 3);
            bus_wr(2'd1, 16'(dv));
            bus_wr(2'd2, fmt_word(len, st2, pen, odd));
            rx_send(d, len, st2, pen, odd, flip, bst, dv);
            bus_rd(2'd3, r);
            check(r[5:2] == {bst, flip, 2'b01}, "R5 R7 rx status", r[5:2], {bst, flip, 2'b01});
            bus_rd(2'd0, r);
            check(r[7:0] == (d & mask_of(len)), "R5 rx data", r[7:0], d & mask_of(len));
            bus_rd(2'd3, r);
            check(r[5:2] == 4'b0000, "R7 errors cleared by read", r[5:2], 0);
        end

        // R6 false start
        bus_wr(2'd1, 16'd2);
        bus_wr(2'd2, fmt_word(2'd3, 1'b0, 1'b0, 1'b0));
        @(negedge clk); rxd = 1'b0;
        repeat (6) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        bus_rd(2'd3, r); check(r[2] == 1'b0, "R6 short pulse rejected", r[2], 0);
        rx_send(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        bus_rd(2'd0, r); check(r[7:0] == 8'h5A, "R6 next frame intact", r[7:0], 8'h5A);

        // R8 overrun
        bus_wr(2'd1, 16'd1);
        a = 8'($urandom); b = ~a;
        rx_send(a, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        rx_send(b, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        bus_rd(2'd3, r); check(r[3:2] == 2'b11, "R8 overrun set", r[3:2], 3);
        bus_rd(2'd0, r); check(r[7:0] == a, "R8 first char kept", r[7:0], a);
        bus_rd(2'd3, r); check(r[3:2] == 2'b00, "R8 overrun cleared", r[3:2], 0);

        // R9 interrupts
        bus_wr(2'd2, 16'h0063);
        @(negedge clk);
        check(irq_tx && !irq_rx, "R9 tx irq on empty", {irq_tx, irq_rx}, 2'b10);
        rx_send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        check(irq_rx, "R9 rx irq on ready", irq_rx, 1);
        bus_wr(2'd2, 16'h0003);
        @(negedge clk);
        check(!irq_rx && !irq_tx, "R9 masked", {irq_tx, irq_rx}, 0);
        bus_rd(2'd0, r);

        // R10 DMA handshakes
        check(dma_tx_req, "R10 tx req when empty", dma_tx_req, 1);
        @(negedge clk); wdata = 16'h0096; dma_tx_ack = 1'b1;
        @(negedge clk); dma_tx_ack = 1'b0;
        check(!dma_tx_req, "R10 tx req drops after ack", dma_tx_req, 0);
        tx_expect(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, 1, "R10 dma tx char");
        repeat (40) @(negedge clk);
        rx_send(8'h4E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        check(dma_rx_req, "R10 rx req on ready", dma_rx_req, 1);
        @(negedge clk); addr = 2'd3; dma_rx_ack = 1'b1;
        #1 r = rdata;
        @(negedge clk); dma_rx_ack = 1'b0;
        check(r[7:0] == 8'h4E, "R10 dma rx data", r[7:0], 8'h4E);
        check(!dma_rx_req, "R10 rx req drops", dma_rx_req, 0);

        // R3 divisor 0 means 65536
        bus_wr(2'd1, 16'd0);
        bus_wr(2'd0, 16'h0055);
        while (txd) @(negedge clk);
        repeat (20000) @(negedge clk);
        check(txd == 1'b0, "R3 divisor zero is 65536", txd, 0);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R1 txd after reset", txd, 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule